// File: doc/BRIEF.md
# Interval Timer with Register Interface

This block is a 32-bit down-counting interval timer that software controls through six 16-bit registers on a small word-addressed write/read bus. Software loads the period in two 16-bit halves. It starts and halts the counter with self-clearing command bits and picks one-shot or continuous operation. The counter moves one step for each pulse on a clock-enable input. When the count passes zero, the timer raises a sticky timeout flag. A level interrupt is asserted while that flag and the interrupt enable are both set. Software reads the live count by writing a snapshot register and then reading the two captured halves.

Run control is a two-state machine. `ST_IDLE` leaves on transition T_START, which is a start command with no stop command. `ST_RUN` returns to `ST_IDLE` on one of three transitions:
- T_STOP: a stop command.
- T_HALT_ON_PERIOD: a write to either period half.
- T_ONESHOT_DONE: a timeout while continuous mode is off.

A timeout in continuous mode stays in `ST_RUN`.

Register word offsets are: 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high.

Top module: `interval_timer`

## Requirements
- R1: After reset all six registers read zero, the interrupt is low, the timer is stopped, and the counter holds all ones (0xFFFFFFFF). A snapshot taken before any period write shows all ones.
- R2: Reads from offsets 6 and 7 return zero. Writes to offsets 6 and 7 change no register.
- R3: Control bit 0 is the interrupt enable and control bit 1 selects continuous mode. Only these two bits are stored, and a control read returns only bits 1:0.
- R4: A control write with bit 2 set and bit 3 clear starts a stopped timer and sets status bit 1 (running). On a timer that is already running, the same write has no effect on the count.
- R5: A control write with bit 3 set stops a running timer and clears status bit 1. When bits 2 and 3 are both set, the timer ends up stopped.
- R6: A write to period low (offset 2) or period high (offset 3) stores only data bits 15:0, stops the timer, and loads the counter with the new 32-bit period {high, low}. This write takes priority over a clock-enable pulse in the same cycle.
- R7: While running, each clock-enable pulse decrements the count. The pulse that finds the count at zero is a timeout: it sets status bit 0 and reloads the period. One interval therefore lasts period+1 pulses.
- R8: On a timeout in one-shot mode the timer stops, and the counter then holds the period value.
- R9: On a timeout in continuous mode the timer keeps running and times out again every period+1 pulses.
- R10: Any write to the status register (offset 0) clears the timeout flag, whatever the data. If a timeout happens in the same cycle, the flag ends up set.
- R11: A write to offset 4 or offset 5 captures the count as it stood before that cycle's pulse. The low half goes to offset 4 and the high half to offset 5.
- R12: The irq output is high exactly when the timeout flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock-enable pulse; one count step per cycle it is high |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data; only bits 15:0 are used |
| bus_rdata | output | 32 | Read data of the addressed register, zero-extended |
| irq | output | 1 | Level interrupt |

## Verification
A register write and a counting pulse can land in the same cycle. The bench provokes this by raising `tick_en` during the write cycle, with the counter at zero or one step away from it. Each such collision has a defined outcome:
- A status write that collides with a timeout must leave the flag set.
- A snapshot write must capture the pre-pulse count. A separate snapshot taken afterwards then shows the stepped value.
- A period write must beat the pulse: no timeout, the timer stopped, and the counter at the new period.

Separately, the bench sweeps periods 0 to 6 in both modes and counts pulses until timeout. It compares each result against period+1.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_CTRL   = 1;
    localparam int unsigned OFS_PER_LO = 2;
    localparam int unsigned OFS_PER_HI = 3;
    localparam int unsigned OFS_SNP_LO = 4;
    localparam int unsigned OFS_SNP_HI = 5;

    localparam int unsigned CMD_START_BIT = 2;
    localparam int unsigned CMD_STOP_BIT  = 3;

endpackage

// File: rtl/itmr_runctl.sv
`timescale 1ns/1ps
module itmr_runctl
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic period_wr,
    input  logic hit,
    input  logic cont,
    output logic running
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                // T_START
                if (start_cmd && !stop_cmd && !period_wr) state_d = ST_RUN;
            end
            ST_RUN: begin
                // T_STOP, T_HALT_ON_PERIOD, T_ONESHOT_DONE
                if (stop_cmd || period_wr || (hit && !cont)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state_q == ST_RUN);
    end

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_cmd && !stop_cmd && !period_wr) |=> running); // R4
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !running); // R5
    AST_PERIOD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> !running); // R6
    AST_ONESHOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cont) |=> !running); // R8
    AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cont && !stop_cmd && !period_wr) |=> running); // R9

endmodule

// File: rtl/itmr_counter.sv
`timescale 1ns/1ps
module itmr_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);

    localparam logic [CNT_W-1:0] CNT_ONES = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic step;
    assign step = running && tick && !load;
    assign hit  = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ONES;
        end else if (load || hit) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R7
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load || hit) |=> (cnt_q == $past(load_val))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/itmr_regs.sv
`timescale 1ns/1ps
module itmr_regs #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic              period_wr,
    output logic [CNT_W-1:0]  period_next,
    output logic              cont,
    output logic              irq
);
    import itmr_pkg::*;

    localparam int unsigned HALF_W = CNT_W / 2;

    logic              wr_status, wr_ctrl, wr_plo, wr_phi, wr_snap;
    logic              to_q, ien_q, cont_q;
    logic [HALF_W-1:0] per_lo_q, per_hi_q, snp_lo_q, snp_hi_q;
    logic [HALF_W-1:0] per_lo_d, per_hi_d;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_status = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_plo    = bus_wr && (bus_addr == ADDR_W'(OFS_PER_LO));
    assign wr_phi    = bus_wr && (bus_addr == ADDR_W'(OFS_PER_HI));
    assign wr_snap   = bus_wr && ((bus_addr == ADDR_W'(OFS_SNP_LO)) ||
                                  (bus_addr == ADDR_W'(OFS_SNP_HI)));

    assign start_cmd = wr_ctrl && bus_wdata[CMD_START_BIT];
    assign stop_cmd  = wr_ctrl && bus_wdata[CMD_STOP_BIT];
    assign period_wr = wr_plo || wr_phi;

    assign per_lo_d    = wr_plo ? bus_wdata[HALF_W-1:0] : per_lo_q;
    assign per_hi_d    = wr_phi ? bus_wdata[HALF_W-1:0] : per_hi_q;
    assign period_next = {per_hi_d, per_lo_d};

    assign cont = cont_q;
    assign irq  = to_q && ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q     <= 1'b0;
            ien_q    <= 1'b0;
            cont_q   <= 1'b0;
            per_lo_q <= '0;
            per_hi_q <= '0;
            snp_lo_q <= '0;
            snp_hi_q <= '0;
        end else begin
            to_q     <= hit || (to_q && !wr_status);
            per_lo_q <= per_lo_d;
            per_hi_q <= per_hi_d;
            if (wr_ctrl) begin
                ien_q  <= bus_wdata[0];
                cont_q <= bus_wdata[1];
            end
            if (wr_snap) begin
                snp_lo_q <= cnt[HALF_W-1:0];
                snp_hi_q <= cnt[CNT_W-1:HALF_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_STATUS): rdata = DATA_W'({running, to_q});
            ADDR_W'(OFS_CTRL):   rdata = DATA_W'({cont_q, ien_q});
            ADDR_W'(OFS_PER_LO): rdata = DATA_W'(per_lo_q);
            ADDR_W'(OFS_PER_HI): rdata = DATA_W'(per_hi_q);
            ADDR_W'(OFS_SNP_LO): rdata = DATA_W'(snp_lo_q);
            ADDR_W'(OFS_SNP_HI): rdata = DATA_W'(snp_hi_q);
            default:             rdata = '0;
        endcase
    end

    AST_TO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> to_q); // R7
    AST_TO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !hit) |=> !to_q); // R10
    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable({cont_q, ien_q})); // R3
    AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_snap |=> $stable({snp_hi_q, snp_lo_q})); // R11

endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             running, hit, start_cmd, stop_cmd, period_wr, cont;
    logic [CNT_W-1:0] cnt, period_next;

    itmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .running     (running),
        .hit         (hit),
        .cnt         (cnt),
        .rdata       (bus_rdata),
        .start_cmd   (start_cmd),
        .stop_cmd    (stop_cmd),
        .period_wr   (period_wr),
        .period_next (period_next),
        .cont        (cont),
        .irq         (irq)
    );

    itmr_runctl u_runctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .period_wr (period_wr),
        .hit       (hit),
        .cont      (cont),
        .running   (running)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .tick     (tick_en),
        .load     (period_wr),
        .load_val (period_next),
        .cnt_q    (cnt),
        .hit      (hit)
    );

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_rdata[0] || bus_addr != 3'd0)); // R12

endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = with_tick;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic read_snap(output logic [31:0] v);
        logic [31:0] lo, hi;
        bus_read(3'd4, lo);
        bus_read(3'd5, hi);
        v = {hi[15:0], lo[15:0]};
    endtask

    task automatic take_snap(output logic [31:0] v);
        bus_write(3'd4, 32'h0, 1'b0);
        read_snap(v);
    endtask

    task automatic set_period(input logic [31:0] p);
        bus_write(3'd3, {16'h0, p[31:16]}, 1'b0);
        bus_write(3'd2, {16'h0, p[15:0]}, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, s;
        int first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), r);
            check("R1 reg reset", r, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq}, 32'h0);
        take_snap(s);
        check("R1 counter all ones", s, 32'hFFFF_FFFF);

        // R4: start from reset counts down from all ones
        bus_write(3'd1, 32'h4, 1'b0);
        bus_read(3'd0, r);
        check("R4 running set", r, 32'h2);
        pulse();
        take_snap(s);
        check("R4 first step", s, 32'hFFFF_FFFE);
        // R4: start while running does not disturb count
        bus_write(3'd1, 32'h4, 1'b0);
        take_snap(s);
        check("R4 start while running", s, 32'hFFFF_FFFE);
        // R5: stop
        bus_write(3'd1, 32'h8, 1'b0);
        bus_read(3'd0, r);
        check("R5 stop clears run", r, 32'h0);
        pulse();
        take_snap(s);
        check("R5 stopped holds", s, 32'hFFFF_FFFE);
        // R5: start+stop together while idle
        bus_write(3'd1, 32'hC, 1'b0);
        bus_read(3'd0, r);
        check("R5 both bits idle", r, 32'h0);

        // R3: control keeps only bits 1:0
        bus_write(3'd1, 32'hFFFF_FFF3 & ~32'hC, 1'b0);
        bus_read(3'd1, r);
        check("R3 ctrl readback", r, 32'h3);
        bus_write(3'd1, 32'h0, 1'b0);

        // R6: period truncation and load
        bus_write(3'd2, 32'hABCD_1234, 1'b0);
        bus_read(3'd2, r);
        check("R6 period low truncated", r, 32'h1234);
        bus_write(3'd3, 32'h5555_0001, 1'b0);
        bus_read(3'd3, r);
        check("R6 period high truncated", r, 32'h1);
        take_snap(s);
        check("R6 counter loaded", s, 32'h0001_1234);
        // R6: period write halts a running timer
        bus_write(3'd1, 32'h4, 1'b0);
        pulse();
        bus_write(3'd2, 32'h0000_1234, 1'b0);
        bus_read(3'd0, r);
        check("R6 period write halts", r, 32'h0);
        take_snap(s);
        check("R6 reload on halt", s, 32'h0001_1234);

        // R2: undefined offsets
        bus_write(3'd1, 32'h1, 1'b0);
        bus_write(3'd6, 32'hFFFF_FFFF, 1'b0);
        bus_write(3'd7, 32'hFFFF_FFFF, 1'b0);
        bus_read(3'd6, r);
        check("R2 offset 6 reads zero", r, 32'h0);
        bus_read(3'd7, r);
        check("R2 offset 7 reads zero", r, 32'h0);
        bus_read(3'd1, r);
        check("R2 ctrl untouched", r, 32'h1);
        bus_read(3'd0, r);
        check("R2 status untouched", r, 32'h0);
        bus_write(3'd1, 32'h0, 1'b0);

        // R7 R8 R9: sweep of periods in both modes
        for (int mode = 0; mode < 2; mode++) begin
            for (int p = 0; p < 7; p++) begin
                bus_write(3'd1, 32'(mode << 1), 1'b0);
                set_period(32'(p));
                bus_write(3'd0, 32'h0, 1'b0);
                bus_write(3'd1, 32'((mode << 1) | 4), 1'b0);
                first = 0;
                for (int n = 1; n <= p + 1; n++) begin
                    pulse();
                    bus_read(3'd0, r);
                    if (r[0] && first == 0) first = n;
                end
                check("R7 pulses to timeout", 32'(first), 32'(p + 1));
                if (mode == 0) begin
                    bus_read(3'd0, r);
                    check("R8 one-shot stops", r, 32'h1);
                    pulse();
                    take_snap(s);
                    check("R8 holds period", s, 32'(p));
                end else begin
                    bus_read(3'd0, r);
                    check("R9 continuous runs", r, 32'h3);
                    bus_write(3'd0, 32'hFFFF, 1'b0);
                    bus_read(3'd0, r);
                    check("R10 status write clears", r, 32'h2);
                    first = 0;
                    for (int n = 1; n <= p + 1; n++) begin
                        pulse();
                        bus_read(3'd0, r);
                        if (r[0] && first == 0) first = n;
                    end
                    check("R9 second interval", 32'(first), 32'(p + 1));
                    bus_write(3'd1, 32'h8, 1'b0);
                end
            end
        end

        // R10: status write colliding with a timeout
        bus_write(3'd1, 32'h2, 1'b0);
        set_period(32'h0);
        bus_write(3'd0, 32'h0, 1'b0);
        bus_write(3'd1, 32'h6, 1'b0);
        bus_write(3'd0, 32'h0, 1'b1);
        bus_read(3'd0, r);
        check("R10 timeout wins collision", r, 32'h3);

        // R12: interrupt follows flag and enable
        check("R12 irq off when disabled", {31'h0, irq}, 32'h0);
        bus_write(3'd1, 32'h3, 1'b0);
        check("R12 irq on", {31'h0, irq}, 32'h1);
        bus_write(3'd0, 32'h0, 1'b0);
        check("R12 irq off after clear", {31'h0, irq}, 32'h0);
        bus_write(3'd1, 32'h8, 1'b0);

        // R11: snapshot captures pre-pulse count
        bus_write(3'd1, 32'h2, 1'b0);
        set_period(32'h3);
        bus_write(3'd1, 32'h6, 1'b0);
        pulse();
        bus_write(3'd5, 32'h0, 1'b1);
        read_snap(s);
        check("R11 pre-pulse capture", s, 32'h2);
        take_snap(s);
        check("R11 later capture", s, 32'h1);

        // R6: period write beats a pulse at terminal count
        pulse();
        bus_write(3'd0, 32'h0, 1'b0);
        bus_write(3'd2, 32'h3, 1'b1);
        bus_read(3'd0, r);
        check("R6 period beats timeout", r, 32'h0);
        take_snap(s);
        check("R6 period load after collision", s, 32'h3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule